// File: doc/BRIEF.md
# Length-Decoded Serial Register Port

This block is the serial programming port of a frequency synthesizer. It is a byte-oriented, SPI-compatible slave. It shifts in data most significant bit first on rising serial clock edges while the active-low select is held low. When select is released, it counts how many bits arrived and uses that count to pick the destination register. No address field is needed.

An eight-bit transfer writes the configuration register. A sixteen-bit transfer fills a buffer for the reference divider. A twenty-four-bit transfer carries the main and swallow divide word. The oldest bit held in the shift register can be routed to a general-purpose output pin as serial data out, so several devices can share one chain.

Neither divide word reaches its counter at once. A main/swallow word waits until the divider chain signals that its counters are reloading. A buffered reference word is first promoted by the next main/swallow write. It then waits for the reference counter's reload strobe. A new reference ratio and a new main ratio therefore enter their counters as one set, and never in the middle of a count.

Top module: `serial_reg_port`

## Requirements
- R1: After reset, the configuration, active reference and active main/swallow outputs are all zero, pin_a is 0, and both detector enables are 0.
- R2: While sel_n is low, each rising sclk edge shifts one sdi bit in at the least significant end, so the first bit sent ends up most significant. Edges of sclk while sel_n is high are neither shifted nor counted.
- R3: A transfer of exactly 8 bits loads cfg_o with the received byte within a few clock cycles after sel_n rises.
- R4: A transfer of exactly 16 bits is held in a reference buffer. ref_o does not change, even on a ref_load pulse, until a later 24-bit transfer has promoted the buffer.
- R5: A transfer of exactly 24 bits becomes a pending main/swallow word. ms_o takes that word only on the clock after an ms_load pulse.
- R6: A 24-bit transfer moves a buffered reference word, if there is one, to a pending slot. ref_o takes that pending word on the clock after a ref_load pulse. Without a pending word, ref_load leaves ref_o unchanged. A second 16-bit transfer before promotion replaces the buffered word.
- R7: A transfer whose length is not 8, 16 or 24 bits (for example 7, 12 or 32) changes no register and leaves no pending word.
- R8: When cfg bit 7 is 1, pin_a carries serial data out. This is the bit shifted in 24 sclk rising edges earlier. When cfg bit 7 is 0, pin_a drives the level of cfg bit 6.
- R9: pd_a_en follows cfg bit 5 and pd_b_en follows cfg bit 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; all serial inputs are sampled on it |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock; data is taken on its rising edge |
| sel_n | input | 1 | Active-low transfer enable; its rising edge ends a transfer |
| sdi | input | 1 | Serial data in, most significant bit first |
| ms_load | input | 1 | Pulse from the main/swallow counters marking a reload |
| ref_load | input | 1 | Pulse from the reference counter marking a reload |
| cfg_o | output | 8 | Configuration register |
| ref_o | output | 16 | Active reference divide word |
| ms_o | output | 24 | Active main/swallow divide word |
| pin_a | output | 1 | Serial data out or general-purpose level, chosen by cfg bit 7 |
| pd_a_en | output | 1 | Enable for detector output A |
| pd_b_en | output | 1 | Enable for detector output B |

## Verification
A wrong bit counter shows up as a whole transfer landing in the wrong register, or in none. This is visible on cfg_o, or on ref_o or ms_o after the next load strobe, within a few clocks of sel_n rising. A wrong pending flag lets a divide output change on a load strobe with no fresh write behind it, or hides a write. Broken promotion of the reference buffer shows as ref_o moving too early or never. A misordered shift register shows on pin_a one sclk edge after the fault, once data-out mode is on.

// File: rtl/srp_pkg.sv
package srp_pkg;
   typedef enum logic [1:0] {
      DST_NONE = 2'd0,
      DST_CFG  = 2'd1,
      DST_REF  = 2'd2,
      DST_MS   = 2'd3
   } dest_e;

   localparam int CFG_PIN_SEL = 7;
   localparam int CFG_PIN_LVL = 6;
   localparam int CFG_PDA_EN  = 5;
   localparam int CFG_PDB_EN  = 4;
endpackage

// File: rtl/srp_sync.sv
module srp_sync #(
   parameter int   DEPTH   = 2,
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   if (DEPTH < 1) begin : g_bad_depth
      $error("srp_sync: DEPTH must be at least 1");
   end

   if (DEPTH == 1) begin : g_single
      logic stg;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stg <= RST_VAL;
         else        stg <= d;
      end
      assign q = stg;
   end else begin : g_chain
      logic [DEPTH-1:0] stg;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stg <= {DEPTH{RST_VAL}};
         else        stg <= {stg[DEPTH-2:0], d};
      end
      assign q = stg[DEPTH-1];
   end
endmodule

// File: rtl/srp_shifter.sv
module srp_shifter #(
   parameter int SR_W  = 24,
   parameter int CNT_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sclk_s,
   input  logic             sel_n_s,
   input  logic             din_s,
   output logic [SR_W-1:0]  shreg,
   output logic [CNT_W-1:0] cnt,
   output logic             done,
   output logic [CNT_W-1:0] len
);
   localparam logic [CNT_W-1:0] SAT = CNT_W'(SR_W + 1);

   logic sclk_p, sel_p;
   logic rise, fin;

   assign rise = sclk_s & ~sclk_p & ~sel_n_s;
   assign fin  = sel_n_s & ~sel_p;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_p <= 1'b0;
         sel_p  <= 1'b1;
      end else begin
         sclk_p <= sclk_s;
         sel_p  <= sel_n_s;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg <= '0;
      end else if (rise) begin
         shreg <= {shreg[SR_W-2:0], din_s};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         done <= 1'b0;
         len  <= '0;
      end else begin
         done <= fin;
         if (fin) begin
            len <= cnt;
            cnt <= '0;
         end else if (rise && cnt != SAT) begin
            cnt <= cnt + 1'b1;
         end
      end
   end
endmodule

// File: rtl/srp_decode.sv
module srp_decode
   import srp_pkg::*;
#(
   parameter int CFG_W = 8,
   parameter int REF_W = 16,
   parameter int MS_W  = 24,
   parameter int CNT_W = 5
) (
   input  logic             done,
   input  logic [CNT_W-1:0] len,
   output dest_e            dest
);
   localparam logic [CNT_W-1:0] LEN_CFG = CNT_W'(CFG_W);
   localparam logic [CNT_W-1:0] LEN_REF = CNT_W'(REF_W);
   localparam logic [CNT_W-1:0] LEN_MS  = CNT_W'(MS_W);

   always_comb begin
      dest = DST_NONE;
      if (done) begin
         if (len == LEN_CFG)      dest = DST_CFG;
         else if (len == LEN_REF) dest = DST_REF;
         else if (len == LEN_MS)  dest = DST_MS;
      end
   end
endmodule

// File: rtl/srp_regs.sv
module srp_regs
   import srp_pkg::*;
#(
   parameter int CFG_W = 8,
   parameter int REF_W = 16,
   parameter int MS_W  = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  dest_e            dest,
   input  logic [MS_W-1:0]  word,
   input  logic             ms_load,
   input  logic             ref_load,
   output logic [CFG_W-1:0] cfg_q,
   output logic [REF_W-1:0] ref_q,
   output logic [MS_W-1:0]  ms_q
);
   logic [REF_W-1:0] ref_buf, ref_pend;
   logic             ref_bv, ref_pv;
   logic [MS_W-1:0]  ms_pend;
   logic             ms_pv;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q <= '0;
      end else if (dest == DST_CFG) begin
         cfg_q <= word[CFG_W-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ms_q    <= '0;
         ms_pend <= '0;
         ms_pv   <= 1'b0;
      end else begin
         if (ms_load && ms_pv) begin
            ms_q  <= ms_pend;
            ms_pv <= 1'b0;
         end
         if (dest == DST_MS) begin
            ms_pend <= word;
            ms_pv   <= 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ref_q    <= '0;
         ref_buf  <= '0;
         ref_bv   <= 1'b0;
         ref_pend <= '0;
         ref_pv   <= 1'b0;
      end else begin
         if (ref_load && ref_pv) begin
            ref_q  <= ref_pend;
            ref_pv <= 1'b0;
         end
         if (dest == DST_REF) begin
            ref_buf <= word[REF_W-1:0];
            ref_bv  <= 1'b1;
         end
         if (dest == DST_MS && ref_bv) begin
            ref_pend <= ref_buf;
            ref_pv   <= 1'b1;
            ref_bv   <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/serial_reg_port.sv
module serial_reg_port
   import srp_pkg::*;
#(
   parameter int CFG_W      = 8,
   parameter int REF_W      = 16,
   parameter int MS_W       = 24,
   parameter int SYNC_DEPTH = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sclk,
   input  logic             sel_n,
   input  logic             sdi,
   input  logic             ms_load,
   input  logic             ref_load,
   output logic [CFG_W-1:0] cfg_o,
   output logic [REF_W-1:0] ref_o,
   output logic [MS_W-1:0]  ms_o,
   output logic             pin_a,
   output logic             pd_a_en,
   output logic             pd_b_en
);
   localparam int CNT_W = $clog2(MS_W + 2);

   if (CFG_W < 8 || (CFG_W % 8) != 0) begin : g_bad_cfg
      $error("serial_reg_port: CFG_W must be a whole number of bytes, at least one");
   end
   if (REF_W <= CFG_W || (REF_W % 8) != 0) begin : g_bad_ref
      $error("serial_reg_port: REF_W must be whole bytes and longer than CFG_W");
   end
   if (MS_W <= REF_W || (MS_W % 8) != 0) begin : g_bad_ms
      $error("serial_reg_port: MS_W must be whole bytes and longer than REF_W");
   end

   logic             sclk_s, sel_s, din_s;
   logic [MS_W-1:0]  shreg;
   logic [CNT_W-1:0] cnt, len;
   logic             done;
   dest_e            dest;
   logic             sdo;

   srp_sync #(.DEPTH(SYNC_DEPTH), .RST_VAL(1'b0)) u_sync_sclk (
      .clk(clk), .rst_n(rst_n), .d(sclk), .q(sclk_s));
   srp_sync #(.DEPTH(SYNC_DEPTH), .RST_VAL(1'b1)) u_sync_sel (
      .clk(clk), .rst_n(rst_n), .d(sel_n), .q(sel_s));
   srp_sync #(.DEPTH(SYNC_DEPTH), .RST_VAL(1'b0)) u_sync_din (
      .clk(clk), .rst_n(rst_n), .d(sdi), .q(din_s));

   srp_shifter #(.SR_W(MS_W), .CNT_W(CNT_W)) u_shift (
      .clk(clk), .rst_n(rst_n), .sclk_s(sclk_s), .sel_n_s(sel_s),
      .din_s(din_s), .shreg(shreg), .cnt(cnt), .done(done), .len(len));

   srp_decode #(.CFG_W(CFG_W), .REF_W(REF_W), .MS_W(MS_W), .CNT_W(CNT_W)) u_dec (
      .done(done), .len(len), .dest(dest));

   srp_regs #(.CFG_W(CFG_W), .REF_W(REF_W), .MS_W(MS_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .dest(dest), .word(shreg),
      .ms_load(ms_load), .ref_load(ref_load),
      .cfg_q(cfg_o), .ref_q(ref_o), .ms_q(ms_o));

   assign sdo     = shreg[MS_W-1];
   assign pin_a   = cfg_o[CFG_PIN_SEL] ? sdo : cfg_o[CFG_PIN_LVL];
   assign pd_a_en = cfg_o[CFG_PDA_EN];
   assign pd_b_en = cfg_o[CFG_PDB_EN];
endmodule

// File: rtl/srp_checker.sv
module srp_checker
   import srp_pkg::*;
#(
   parameter int CFG_W = 8,
   parameter int REF_W = 16,
   parameter int MS_W  = 24,
   parameter int CNT_W = 5
) (
   input logic             clk,
   input logic             rst_n,
   input logic [CFG_W-1:0] cfg_o,
   input logic [REF_W-1:0] ref_o,
   input logic [MS_W-1:0]  ms_o,
   input logic             ms_load,
   input logic             ref_load,
   input dest_e            dest,
   input logic [CNT_W-1:0] cnt,
   input logic [MS_W-1:0]  shreg,
   input logic             sel_s
);
   AST_CNT_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CNT_W'(MS_W + 1)); // R7

   AST_SHIFT_WHEN_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(shreg) |-> !$past(sel_s)); // R2

   AST_CFG_ON_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(cfg_o) |-> $past(dest == DST_CFG)); // R3

   AST_MS_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(ms_o) |-> $past(ms_load)); // R5

   AST_REF_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(ref_o) |-> $past(ref_load)); // R6
endmodule

bind serial_reg_port srp_checker #(
   .CFG_W(CFG_W), .REF_W(REF_W), .MS_W(MS_W), .CNT_W(CNT_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .cfg_o(cfg_o), .ref_o(ref_o), .ms_o(ms_o),
   .ms_load(ms_load), .ref_load(ref_load), .dest(dest), .cnt(cnt),
   .shreg(shreg), .sel_s(sel_s)
);

// File: tb/serial_reg_port_test.sv
module serial_reg_port_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sclk = 1'b0, sel_n = 1'b1, sdi = 1'b0;
   logic        ms_load = 1'b0, ref_load = 1'b0;
   logic [7:0]  cfg_o;
   logic [15:0] ref_o;
   logic [23:0] ms_o;
   logic        pin_a, pd_a_en, pd_b_en;

   int n_cmp = 0;
   int n_bad = 0;
   bit mon_on = 1'b0;
   bit finished = 1'b0;

   logic [7:0]  q_cfg[$];
   logic [15:0] q_ref[$];
   logic [23:0] q_ms[$];

   logic [15:0] m_rbuf, m_rpend;
   bit          m_rbv = 0, m_rpv = 0;
   logic [23:0] m_mpend;
   bit          m_mpv = 0;

   always #2 clk = ~clk;

   serial_reg_port uut (
      .clk(clk), .rst_n(rst_n), .sclk(sclk), .sel_n(sel_n), .sdi(sdi),
      .ms_load(ms_load), .ref_load(ref_load), .cfg_o(cfg_o), .ref_o(ref_o),
      .ms_o(ms_o), .pin_a(pin_a), .pd_a_en(pd_a_en), .pd_b_en(pd_b_en));

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   // Shift n bits of v, MSB first; optionally check serial data out (R8)
   task automatic send(input logic [31:0] v, input int n, input bit chk_sdo);
      sel_n = 1'b0;
      wait_n(4);
      for (int k = 1; k <= n; k++) begin
         sdi  = v[n-k];
         sclk = 1'b0;
         wait_n(4);
         sclk = 1'b1;
         wait_n(4);
         if (chk_sdo && k >= 24) chk("R8 sdo", {31'd0, pin_a}, {31'd0, v[n-1-(k-24)]});
      end
      sclk = 1'b0;
      wait_n(4);
      sel_n = 1'b1;
      wait_n(8);
   endtask

   task automatic write_cfg(input logic [7:0] v);
      q_cfg.push_back(v);
      send({24'd0, v}, 8, 1'b0);
   endtask

   task automatic write_ref(input logic [15:0] v);
      send({16'd0, v}, 16, 1'b0);
      m_rbuf = v;
      m_rbv  = 1;
   endtask

   task automatic write_ms(input logic [23:0] v);
      send({8'd0, v}, 24, 1'b0);
      m_mpend = v;
      m_mpv   = 1;
      if (m_rbv) begin
         m_rpend = m_rbuf;
         m_rpv   = 1;
         m_rbv   = 0;
      end
   endtask

   task automatic pulse(input bit do_ms, input bit do_ref);
      if (do_ms && m_mpv) begin q_ms.push_back(m_mpend); m_mpv = 0; end
      if (do_ref && m_rpv) begin q_ref.push_back(m_rpend); m_rpv = 0; end
      ms_load  = do_ms;
      ref_load = do_ref;
      wait_n(1);
      ms_load  = 1'b0;
      ref_load = 1'b0;
      wait_n(4);
   endtask

   // Monitor: every change of a register output is matched to the queue head
   logic [7:0]  p_cfg;
   logic [15:0] p_ref;
   logic [23:0] p_ms;
   always @(negedge clk) begin
      if (mon_on) begin
         if (cfg_o !== p_cfg) begin
            if (q_cfg.size() == 0) chk("R3 cfg_o unexpected", {24'd0, cfg_o}, {24'd0, p_cfg});
            else chk("R3 cfg_o", {24'd0, cfg_o}, {24'd0, q_cfg.pop_front()});
         end
         if (ref_o !== p_ref) begin
            if (q_ref.size() == 0) chk("R6 ref_o unexpected", {16'd0, ref_o}, {16'd0, p_ref});
            else chk("R6 ref_o", {16'd0, ref_o}, {16'd0, q_ref.pop_front()});
         end
         if (ms_o !== p_ms) begin
            if (q_ms.size() == 0) chk("R5 ms_o unexpected", {8'd0, ms_o}, {8'd0, p_ms});
            else chk("R5 ms_o", {8'd0, ms_o}, {8'd0, q_ms.pop_front()});
         end
      end
      p_cfg = cfg_o;
      p_ref = ref_o;
      p_ms  = ms_o;
   end

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_cmp++;
         n_bad++;
         $display("FAIL R1 watchdog act=running exp=finished");
         summary();
         $finish;
      end
   end

   initial begin
      wait_n(3);
      rst_n = 1'b1;
      wait_n(2);
      // R1 reset state
      chk("R1 cfg_o", {24'd0, cfg_o}, 32'd0);
      chk("R1 ref_o", {16'd0, ref_o}, 32'd0);
      chk("R1 ms_o", {8'd0, ms_o}, 32'd0);
      chk("R1 pins", {29'd0, pin_a, pd_a_en, pd_b_en}, 32'd0);
      mon_on = 1'b1;

      // R2: sclk edges with sel_n high are ignored
      sdi = 1'b1;
      for (int i = 0; i < 5; i++) begin
         sclk = 1'b1; wait_n(4);
         sclk = 1'b0; wait_n(4);
      end
      write_cfg(8'h40);
      chk("R2 cfg after idle edges", {24'd0, cfg_o}, 32'h40);
      chk("R8 pin level mode", {31'd0, pin_a}, 32'd1);
      chk("R9 enables off", {30'd0, pd_a_en, pd_b_en}, 32'd0);

      // R9 and R8 data-out mode, then a 32-bit discarded frame (R7)
      write_cfg(8'hB0);
      chk("R9 enables on", {30'd0, pd_a_en, pd_b_en}, 32'd3);
      send(32'hA5C3_1E69, 32, 1'b1);
      chk("R7 cfg after 32 bits", {24'd0, cfg_o}, 32'hB0);

      // R4: buffered reference is not visible yet
      write_ref(16'h1234);
      chk("R4 ref_o after write", {16'd0, ref_o}, 32'd0);
      pulse(1'b0, 1'b1);
      chk("R4 ref_o after early load", {16'd0, ref_o}, 32'd0);

      // R5/R6: 24-bit write promotes reference; each waits for its load
      write_ms(24'h0ABCDE);
      chk("R5 ms_o before load", {8'd0, ms_o}, 32'd0);
      chk("R6 ref_o before load", {16'd0, ref_o}, 32'd0);
      pulse(1'b0, 1'b1);
      chk("R6 ref_o loaded", {16'd0, ref_o}, 32'h1234);
      pulse(1'b1, 1'b0);
      chk("R5 ms_o loaded", {8'd0, ms_o}, 32'h0ABCDE);

      // R7: odd lengths discarded
      send(32'h0000_0ACE, 12, 1'b0);
      send(32'h0000_0055, 7, 1'b0);
      chk("R7 cfg after 12/7 bits", {24'd0, cfg_o}, 32'hB0);
      pulse(1'b1, 1'b1);
      chk("R7 ms_o no pending", {8'd0, ms_o}, 32'h0ABCDE);

      // R6: main write without new reference leaves ref_o alone
      write_ms(24'h123456);
      pulse(1'b1, 1'b1);
      chk("R6 ref_o kept", {16'd0, ref_o}, 32'h1234);
      chk("R5 ms_o second", {8'd0, ms_o}, 32'h123456);

      // R6: second reference write replaces buffer; simultaneous loads
      write_ref(16'h0FED);
      write_ref(16'h0777);
      write_ms(24'hFEDCBA);
      pulse(1'b1, 1'b1);
      chk("R6 ref_o replaced", {16'd0, ref_o}, 32'h0777);
      chk("R5 ms_o third", {8'd0, ms_o}, 32'hFEDCBA);

      // R9/R8: detector A only, pin level from bit 6 = 0
      write_cfg(8'h20);
      chk("R9 enables A only", {30'd0, pd_a_en, pd_b_en}, 32'd2);
      chk("R8 pin level low", {31'd0, pin_a}, 32'd0);

      wait_n(4);
      chk("R3 cfg queue drained", q_cfg.size(), 32'd0);
      chk("R6 ref queue drained", q_ref.size(), 32'd0);
      chk("R5 ms queue drained", q_ms.size(), 32'd0);
      finished = 1'b1;
      summary();
      $finish;
   end
endmodule